// File: doc/BRIEF.md
# SPI Byte Transfer Engine

This block is the data path of an SPI host. Software-side logic pushes bytes into an eight-entry transmit queue. A shift engine takes them out one at a time and sends each byte most significant bit first on the serial output, while it collects a byte from the serial input. The serial clock comes from a programmable divider of the system clock. Received bytes enter an eight-entry receive queue, from which the host logic pops them. The engine starts transfers back to back for as long as the transmit queue holds data.

A transmit-only setting throws away every received byte. When the receive queue is full, the byte just received is lost, but the transfer itself and the ones after it run normally. Each queue can be cleared on its own. Chip-select sequencing is not handled here.

Top module: `spi_xfer_engine`

## Requirements
- R1: Each queue holds up to 8 bytes and reports its fill count, full and empty. A push into a full queue and a pop from an empty queue are ignored, so the count never goes above 8.
- R2: When a push and a pop on a non-empty, non-full queue are accepted in the same cycle, its count stays the same.
- R3: The receive output always shows the oldest stored byte, and bytes leave in the order they arrived.
- R4: A clear strobe empties its queue by the next cycle. Empty is then set, and a push in that same cycle is dropped.
- R5: When the engine is idle and the transmit queue is not empty, it pops one byte in that cycle and becomes busy on the next edge. Queued bytes go out one after another with no host action.
- R6: SCK makes 16 edges per byte, and each half-period is div_i+1 system cycles. Between transfers SCK rests at the polarity level, mode_i[1].
- R7: Bits are sent and received MSB first. With mode_i[0]=0, the input is sampled on the first edge of each bit pair and the output moves on the second edge. With mode_i[0]=1, the output moves on the first edge and the input is sampled on the second edge.
- R8: While tx_only_i is 1, no received byte enters the receive queue.
- R9: A byte received while the receive queue is full is discarded. Its transfer still makes all 16 edges, and later queued bytes are still sent.
- R10: busy_o rises one cycle after the pop and falls on the cycle of the 16th SCK edge. That is 16*(div_i+1) cycles after it rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Half-period of SCK minus one, in system cycles |
| mode_i | input | 2 | Bit 0 selects the clock phase, bit 1 selects the clock polarity |
| tx_only_i | input | 1 | Discard received bytes |
| tx_push_i | input | 1 | Write tx_data_i into the transmit queue |
| tx_data_i | input | 8 | Byte to send |
| tx_clr_i | input | 1 | Empty the transmit queue |
| rx_pop_i | input | 1 | Remove the head of the receive queue |
| rx_clr_i | input | 1 | Empty the receive queue |
| rx_data_o | output | 8 | Oldest received byte |
| tx_count_o | output | CNT_W | Transmit queue fill level |
| rx_count_o | output | CNT_W | Receive queue fill level |
| tx_full_o | output | 1 | Transmit queue full |
| tx_empty_o | output | 1 | Transmit queue empty |
| rx_full_o | output | 1 | Receive queue full |
| rx_empty_o | output | 1 | Receive queue empty |
| busy_o | output | 1 | A byte is being shifted |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The bench contains a bus-side device model. For every clock mode it shifts a response byte that changes from transfer to transfer and records what arrives on the serial output. The bench sweeps all four modes against several divider values. The recorded bytes catch any swap of bit order or sampling edge. The timing of each SCK edge separates a wrong half-period from a wrong edge count. Streams of ten bytes with a slow divider fill the transmit queue and overflow the receive queue. Single pushes, and pushes in two adjacent cycles, measure the exact cycle busy_o rises and falls, and the push-while-pop case.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned FIFO_DEPTH = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o && !clr_i;
  assign do_pop  = pop_i && !empty_o && !clr_i;
  assign data_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned BITS  = 8,
  localparam int unsigned EW   = $clog2(2 * BITS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic            cpha_i,
  input  logic            start_i,
  input  logic [BITS-1:0] data_i,
  input  logic            miso_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            phase_o,
  output logic            mosi_o,
  output logic [BITS-1:0] rx_byte_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [EW-1:0]    edge_q;
  logic             busy_q, phase_q, done_q;
  logic [BITS-1:0]  tx_sr_q, rx_sr_q;
  logic             lead, last, sample, hold;

  assign lead   = !edge_q[0];
  assign last   = (edge_q == EW'(2 * BITS - 1));
  assign sample = lead ^ cpha_i;
  // no output move before the first bit (phase 1) or after the last (phase 0)
  assign hold   = cpha_i ? (edge_q == '0) : last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      edge_q  <= '0;
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      done_q  <= 1'b0;
      tx_sr_q <= '0;
      rx_sr_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q  <= 1'b1;
        cnt_q   <= div_i;
        edge_q  <= '0;
        phase_q <= 1'b0;
        tx_sr_q <= data_i;
      end else if (busy_q) begin
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end else begin
          cnt_q   <= div_i;
          phase_q <= ~phase_q;
          edge_q  <= edge_q + 1'b1;
          if (sample)     rx_sr_q <= {rx_sr_q[BITS-2:0], miso_i};
          else if (!hold) tx_sr_q <= {tx_sr_q[BITS-2:0], 1'b0};
          if (last) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign phase_o   = phase_q;
  assign mosi_o    = tx_sr_q[BITS-1];
  assign rx_byte_o = rx_sr_q;
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_xfer_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned DEPTH = FIFO_DEPTH,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic [1:0]       mode_i,
  input  logic             tx_only_i,
  input  logic             tx_push_i,
  input  logic [7:0]       tx_data_i,
  input  logic             tx_clr_i,
  input  logic             rx_pop_i,
  input  logic             rx_clr_i,
  output logic [7:0]       rx_data_o,
  output logic [CNT_W-1:0] tx_count_o,
  output logic [CNT_W-1:0] rx_count_o,
  output logic             tx_full_o,
  output logic             tx_empty_o,
  output logic             rx_full_o,
  output logic             rx_empty_o,
  output logic             busy_o,
  output logic             sck_o,
  output logic             mosi_o,
  input  logic             miso_i
);
  byte_t tx_head, rx_byte;
  logic  tx_pop, rx_push, done, phase;

  assign tx_pop  = !busy_o && !tx_empty_o && !tx_clr_i;
  assign rx_push = done && !tx_only_i;

  spi_byte_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_tx_fifo (
    .clk_i, .rst_ni,
    .clr_i   (tx_clr_i),
    .push_i  (tx_push_i),
    .data_i  (tx_data_i),
    .pop_i   (tx_pop),
    .data_o  (tx_head),
    .count_o (tx_count_o),
    .full_o  (tx_full_o),
    .empty_o (tx_empty_o)
  );

  spi_bit_shifter #(.DIV_W(DIV_W), .BITS(BYTE_W)) u_shift (
    .clk_i, .rst_ni,
    .div_i,
    .cpha_i    (mode_i[0]),
    .start_i   (tx_pop),
    .data_i    (tx_head),
    .miso_i,
    .busy_o,
    .done_o    (done),
    .phase_o   (phase),
    .mosi_o,
    .rx_byte_o (rx_byte)
  );

  spi_byte_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_rx_fifo (
    .clk_i, .rst_ni,
    .clr_i   (rx_clr_i),
    .push_i  (rx_push),
    .data_i  (rx_byte),
    .pop_i   (rx_pop_i),
    .data_o  (rx_data_o),
    .count_o (rx_count_o),
    .full_o  (rx_full_o),
    .empty_o (rx_empty_o)
  );

  assign sck_o = mode_i[1] ^ phase;
endmodule

// File: rtl/spi_xfer_engine_chk.sv
module spi_xfer_engine_chk #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic             tx_only_i,
  input logic             tx_push_i,
  input logic             tx_clr_i,
  input logic             rx_pop_i,
  input logic             rx_clr_i,
  input logic [CNT_W-1:0] tx_count_o,
  input logic [CNT_W-1:0] rx_count_o,
  input logic             tx_full_o,
  input logic             tx_empty_o,
  input logic             rx_full_o,
  input logic             rx_empty_o,
  input logic             busy_o,
  input logic             sck_o
);
  a_r1_tx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_count_o <= CNT_W'(DEPTH));

  a_r1_rx_full_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_full_o && !rx_pop_i && !rx_clr_i |=> rx_full_o);

  a_r2_push_pop_same: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push_i && !tx_full_o && !tx_empty_o && !busy_o && !tx_clr_i |=> $stable(tx_count_o));

  a_r4_rx_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_clr_i |=> rx_empty_o && rx_count_o == '0);

  a_r5_start_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(!tx_empty_o));

  a_r10_start_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !tx_empty_o && !tx_clr_i |=> busy_o);

  a_r6_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> sck_o == mode_i[1]);

  a_r8_no_rx_growth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_only_i |=> rx_count_o <= $past(rx_count_o));
endmodule

bind spi_xfer_engine spi_xfer_engine_chk #(.DIV_W(DIV_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/spi_xfer_engine_tb.sv
module spi_xfer_engine_tb;
  localparam int DIV_W = 8;
  localparam int CNT_W = 4;

  logic clk = 0, rst_n = 0;
  logic [DIV_W-1:0] div = 0;
  logic [1:0] mode = 0;
  logic tx_only = 0, tx_push = 0, tx_clr = 0, rx_pop = 0, rx_clr = 0;
  logic [7:0] tx_data = 0, rx_data;
  logic [CNT_W-1:0] tx_count, rx_count;
  logic tx_full, tx_empty, rx_full, rx_empty, busy, sck, mosi, miso = 0;

  always #5 clk = ~clk;

  spi_xfer_engine #(.DIV_W(DIV_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .mode_i(mode), .tx_only_i(tx_only),
    .tx_push_i(tx_push), .tx_data_i(tx_data), .tx_clr_i(tx_clr), .rx_pop_i(rx_pop),
    .rx_clr_i(rx_clr), .rx_data_o(rx_data), .tx_count_o(tx_count), .rx_count_o(rx_count),
    .tx_full_o(tx_full), .tx_empty_o(tx_empty), .rx_full_o(rx_full), .rx_empty_o(rx_empty),
    .busy_o(busy), .sck_o(sck), .mosi_o(mosi), .miso_i(miso)
  );

  int checks = 0, fails = 0, n_tx = 0;
  bit finished = 0;
  logic [7:0] exp_tx [0:255];

  function automatic logic [7:0] resp(input int k);
    return 8'hA5 ^ 8'(k * 29);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // device model on the serial side, updated mid-cycle
  int s_idx = 0, s_err = 0, s_edges = 0, s_cyc = 0, s_last = 0;
  logic [7:0] s_out = 0, s_cap = 0;
  logic s_busy_prev = 0, s_sck_prev = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      s_busy_prev = 0;
      s_sck_prev  = mode[1];
    end else begin
      if (busy && !s_busy_prev) begin
        s_out = resp(s_idx); s_cap = 0; s_edges = 0; s_last = s_cyc;
        if (!mode[0]) begin miso = s_out[7]; s_out = s_out << 1; end
      end
      if ((busy || s_busy_prev) && sck != s_sck_prev) begin
        s_edges++;
        if (s_cyc - s_last != int'(div) + 1) s_err++;
        s_last = s_cyc;
        if ((sck != mode[1]) ^ mode[0]) s_cap = {s_cap[6:0], mosi};
        else begin miso = s_out[7]; s_out = s_out << 1; end
      end
      if (!busy && s_busy_prev) begin
        if (s_edges != 16 || s_cap != exp_tx[s_idx[7:0]] || sck != mode[1]) s_err++;
        s_idx++;
      end
      s_busy_prev = busy;
      s_sck_prev  = sck;
      s_cyc++;
    end
  end

  task automatic push_seq(input int n, input logic [7:0] first, input int rec);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_push = 1; tx_data = first + 8'(i * 17);
      if (i < rec) begin exp_tx[n_tx[7:0]] = tx_data; n_tx++; end
    end
    @(negedge clk);
    tx_push = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(tx_empty && !busy));
    repeat (3) @(negedge clk);
  endtask

  task automatic pop_chk(input logic [7:0] exp, input string tag);
    chk(rx_data == exp, tag, rx_data, exp);
    rx_pop = 1;
    @(negedge clk);
    rx_pop = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk(tx_count == 0 && rx_count == 0, "R1 reset counts", {tx_count, rx_count}, 0);
    chk(tx_empty && rx_empty && !tx_full && !rx_full, "R1 reset flags",
        {tx_empty, rx_empty, tx_full, rx_full}, 4'b1100);
    chk(!busy && sck == 0, "R10 reset idle", {busy, sck}, 0);

    // R6 R7 sweep of modes and dividers
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 4; d++) begin
        mode = 2'(m);
        div = (d == 3) ? 8'd5 : 8'(d);
        @(negedge clk);
        base = n_tx;
        push_seq(3, 8'(m * 64 + d * 8 + 1), 3);
        wait_idle();
        chk(rx_count == 3, "R5 rx count after burst", rx_count, 3);
        for (int j = 0; j < 3; j++) pop_chk(resp(base + j), "R7 R3 received byte");
        chk(s_err == 0, "R6 R7 edges, timing and sent bytes", s_err, 0);
        chk(sck == mode[1], "R6 idle level", sck, mode[1]);
      end
    end

    // R10 busy timing, div=2
    mode = 0; div = 2;
    @(negedge clk);
    tx_push = 1; tx_data = 8'h96; exp_tx[n_tx[7:0]] = 8'h96; base = n_tx; n_tx++;
    @(negedge clk);
    tx_push = 0;
    chk(!busy && tx_count == 1, "R10 not busy at push", {busy, tx_count}, 1);
    @(negedge clk);
    chk(busy && tx_count == 0, "R5 R10 popped and busy", {busy, tx_count}, 5'h10);
    repeat (47) @(negedge clk);
    chk(busy, "R10 busy before last edge", busy, 1);
    @(negedge clk);
    chk(!busy, "R10 busy low after 16th edge", busy, 0);
    wait_idle();
    pop_chk(resp(base), "R7 single byte");

    // R2 push in the cycle the engine pops
    mode = 2'b11; div = 5;
    @(negedge clk);
    base = n_tx;
    push_seq(2, 8'h3C, 2);
    chk(tx_count == 1, "R2 push with pop keeps count", tx_count, 1);
    wait_idle();
    pop_chk(resp(base), "R2 first byte");
    pop_chk(resp(base + 1), "R2 second byte");

    // R1 R9 tx overflow and rx overflow, div=7
    mode = 2'b01; div = 7;
    @(negedge clk);
    base = n_tx;
    push_seq(10, 8'h11, 9);
    chk(tx_full && tx_count == 8, "R1 tx full, push dropped", tx_count, 8);
    wait_idle();
    chk(rx_full && rx_count == 8, "R9 rx held at 8", rx_count, 8);
    chk(s_idx == base + 9 && s_err == 0, "R9 transfers complete", s_idx, base + 9);
    for (int j = 0; j < 8; j++) pop_chk(resp(base + j), "R9 R3 kept bytes");
    chk(rx_empty && rx_count == 0, "R1 rx drained", rx_count, 0);
    rx_pop = 1;
    @(negedge clk);
    rx_pop = 0;
    chk(rx_empty && rx_count == 0, "R1 pop on empty ignored", rx_count, 0);

    // R8 transmit-only
    tx_only = 1; mode = 2'b10; div = 1;
    @(negedge clk);
    push_seq(3, 8'hE0, 3);
    wait_idle();
    chk(rx_count == 0 && rx_empty, "R8 nothing received", rx_count, 0);
    chk(s_idx == n_tx && s_err == 0, "R8 bytes still sent", s_idx, n_tx);
    tx_only = 0;

    // R4 clears
    mode = 0; div = 7;
    @(negedge clk);
    push_seq(4, 8'h70, 1);
    chk(tx_count == 3, "R4 tx before clear", tx_count, 3);
    tx_clr = 1;
    @(negedge clk);
    tx_clr = 0;
    chk(tx_count == 0 && tx_empty, "R4 tx cleared", tx_count, 0);
    wait_idle();
    chk(s_idx == n_tx && s_err == 0, "R4 in-flight byte finished", s_idx, n_tx);
    chk(rx_count == 1, "R4 rx before clear", rx_count, 1);
    rx_clr = 1;
    @(negedge clk);
    rx_clr = 0;
    chk(rx_count == 0 && rx_empty, "R4 rx cleared", rx_count, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule